// File: doc/BRIEF.md
# Command-Driven Quad SPI Word Engine

This block is a register-programmed serial flash master. Software programs a clock divider and a device-control word that holds per-select clock polarity, select polarity and clock phase. It then writes a command word, and that write launches exactly one serial word. The command word chooses the select line, the word length, the frame length and the transfer kind. The transfer kind is a single-line write, a read over one, two or four data lines, or an invalidate. Bit 14 of the command word arms a word-complete interrupt.

The select line, once asserted by the first command of a frame, stays asserted across later commands. It is released when the programmed number of words has completed or when an invalidate command arrives. The link is half duplex. Write data is loaded into the data register before the command. Read data is taken from the same register once the busy flag drops. A command written while a word is still shifting is dropped and sets a sticky error flag.

The register bus is a plain single-cycle write strobe with a word address and a combinational read port.

Top module: `qspi_cmd_engine`

## Requirements
- R1: Command word fields: function at bits 18:16, where 2 is a single-line write, 1 a single-line read, 3 a dual read, 7 a quad read and 4 an invalidate. Any other code does nothing. A write drives the word MSB first on dq_o[0] with dq_oe[0] high for the whole word, and it uses the low bits of the data register (word address 4).
- R2: A single-line read samples dq_i[1], a dual read samples dq_i[1:0] and a quad read samples dq_i[3:0], the higher line carrying the more significant bit in each case. Words are received MSB first. The data register read returns the word right aligned with the upper bits zero.
- R3: Word length is coded as bits minus one in bits 23:19 of the command. Lengths 8, 16 and 32 are supported.
- R4: Let D be the 16-bit divider from clock-control bits 15:0, with a value of 0 treated as 1. Each serial clock period then lasts D+1 functional cycles, and the busy flag stays high for exactly (bits/lines)*(D+1) cycles.
- R5: Clock-control bit 31 enables the serial clock. While it is clear, a launched word makes no progress: busy stays high and sclk_o does not move.
- R6: Select n owns device-control bits 8n+2:8n. Bit 0 of that lane is the idle clock level, bit 1 is the select polarity (1 means active high) and bit 2 is the clock phase. With phase 0, data is sampled on the leading edge and changes on the trailing edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R7: The select index (bits 29:28) and the frame length in words minus one (bits 11:0) are taken from the command that opens a frame. The select stays active between words and is released when the completed word count reaches the frame length.
- R8: An invalidate command issued while idle releases the select in the next cycle. It shifts nothing and raises no interrupt.
- R9: Status (word address 3) bit 0 is busy. A command written while busy is ignored: the command readback at address 2 is unchanged and no other select moves. It also sets sticky status bit 2, which is cleared by writing 1 to that bit.
- R10: Word completion of a command with bit 14 set sets raw bit 1 (address 5). Writing 1 to bit 1 at address 7 sets the enable and at address 8 clears it. Address 6 reads raw AND enable, and writing 1 there clears the raw bit. irq_o is raw AND enable.
- R11: After reset the clock-control word (address 0) and status read 0, every select is at its inactive level (high) and sclk_o and irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| sclk_o | output | 1 | Serial clock |
| cs_o | output | NCS | Select lines, level per lane polarity |
| dq_o | output | 4 | Serial data out |
| dq_oe | output | 4 | Serial data output enables |
| dq_i | input | 4 | Serial data in |
| irq_o | output | 1 | Word-complete interrupt |

## Verification
A wrong slot or bit count in the shifter shows up on the first affected word in two ways: the busy window differs from (bits/lines)*(D+1) cycles, and the captured or returned word is shifted or truncated. A stuck frame counter shows up after the first word of a frame, with the select released too early or held after the last word. A wrong phase or polarity choice corrupts the data on the very next word. The randomized runs cover every lane setting and line width, and each run compares data, busy length and select level.

// File: rtl/qspi_ce_pkg.sv
package qspi_ce_pkg;
  // register word addresses
  localparam logic [3:0] A_CLK   = 4'd0;
  localparam logic [3:0] A_DEV   = 4'd1;
  localparam logic [3:0] A_CMD   = 4'd2;
  localparam logic [3:0] A_STAT  = 4'd3;
  localparam logic [3:0] A_DATA  = 4'd4;
  localparam logic [3:0] A_IRAW  = 4'd5;
  localparam logic [3:0] A_IENS  = 4'd6;
  localparam logic [3:0] A_IESET = 4'd7;
  localparam logic [3:0] A_IECLR = 4'd8;
  // command function codes
  localparam logic [2:0] FN_RD1 = 3'd1;
  localparam logic [2:0] FN_WR1 = 3'd2;
  localparam logic [2:0] FN_RD2 = 3'd3;
  localparam logic [2:0] FN_INV = 3'd4;
  localparam logic [2:0] FN_RD4 = 3'd7;
  // command field positions
  localparam int CMD_CS_LSB = 28;
  localparam int CMD_WL_LSB = 19;
  localparam int CMD_FN_LSB = 16;
  localparam int CMD_IE_BIT = 14;
endpackage

// File: rtl/qspi_ce_bittimer.sv
module qspi_ce_bittimer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clk_en,
  input  logic [DIV_W-1:0] div,
  output logic             lead,
  output logic             trail,
  output logic             slot_end,
  output logic             phase
);
  logic [DIV_W-1:0] cnt_q, cnt_d, span, half;
  logic [DIV_W:0]   span_p1;
  logic             ph_q, ph_d, tick;

  assign span    = (div == '0) ? DIV_W'(1) : div;
  assign span_p1 = {1'b0, span} + 1'b1;
  assign half    = span_p1[DIV_W:1];
  assign tick    = run & clk_en;

  assign lead     = tick & (cnt_q == '0);
  assign trail    = tick & (cnt_q == half);
  assign slot_end = tick & (cnt_q == span);
  assign phase    = ph_q;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!run) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (clk_en) begin
      cnt_d = slot_end ? '0 : cnt_q + 1'b1;
      if (lead)       ph_d = 1'b1;
      else if (trail) ph_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  // R5: a gated serial clock holds its phase
  a_r5_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clk_en) |=> $stable(ph_q));
  // R4: a leading edge opens the active half period
  a_r4_lead_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (lead && !trail) |=> ph_q);
endmodule

// File: rtl/qspi_ce_shifter.sv
module qspi_ce_shifter
  import qspi_ce_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  fn,
  input  logic [4:0]  wl,
  input  logic [31:0] txw,
  input  logic        cpha,
  input  logic        lead,
  input  logic        trail,
  input  logic        slot_end,
  input  logic [3:0]  dq_i,
  output logic        busy,
  output logic        done,
  output logic [31:0] rxw,
  output logic        tx_bit,
  output logic        tx_oe
);
  logic        busy_q, busy_d, first_q, first_d;
  logic [31:0] tx_q, tx_d, rx_q, rx_d;
  logic [5:0]  slot_q, slot_d, nb, last_slot;
  logic [2:0]  fn_q, fn_d;
  logic [4:0]  wl_q, wl_d;
  logic [1:0]  lsh;
  logic        samp, shf;

  always_comb begin
    case (fn_q)
      FN_RD4:  lsh = 2'd2;
      FN_RD2:  lsh = 2'd1;
      default: lsh = 2'd0;
    endcase
  end

  assign nb        = {1'b0, wl_q} + 6'd1;
  assign last_slot = (nb >> lsh) - 6'd1;
  assign samp      = cpha ? trail : lead;
  assign shf       = cpha ? (lead & ~first_q) : trail;
  assign done      = busy_q & slot_end & (slot_q == last_slot);
  assign busy      = busy_q;
  assign rxw       = rx_q;
  assign tx_bit    = tx_q[31];
  assign tx_oe     = busy_q & (fn_q == FN_WR1);

  always_comb begin
    busy_d  = busy_q;
    first_d = first_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    slot_d  = slot_q;
    fn_d    = fn_q;
    wl_d    = wl_q;
    if (start) begin
      busy_d  = 1'b1;
      first_d = 1'b1;
      tx_d    = txw << (5'd31 - wl);
      rx_d    = '0;
      slot_d  = '0;
      fn_d    = fn;
      wl_d    = wl;
    end else if (busy_q) begin
      if (lead) first_d = 1'b0;
      if (shf)  tx_d = {tx_q[30:0], 1'b0};
      if (samp) begin
        case (fn_q)
          FN_RD4:  rx_d = {rx_q[27:0], dq_i[3:0]};
          FN_RD2:  rx_d = {rx_q[29:0], dq_i[1:0]};
          FN_RD1:  rx_d = {rx_q[30:0], dq_i[1]};
          default: rx_d = rx_q;
        endcase
      end
      if (done)          busy_d = 1'b0;
      else if (slot_end) slot_d = slot_q + 6'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      slot_q  <= '0;
      fn_q    <= '0;
      wl_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      first_q <= first_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      slot_q  <= slot_d;
      fn_q    <= fn_d;
      wl_q    <= wl_d;
    end
  end

  // R9: busy drops right after the last slot of the word
  a_r9_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
  // R3: the slot counter never passes the last slot of the word
  a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (slot_q <= last_slot));
endmodule

// File: rtl/qspi_ce_frame.sv
module qspi_ce_frame #(
  parameter int NCS    = 4,
  parameter int FLEN_W = 12,
  localparam int CS_W  = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              inval,
  input  logic              done,
  input  logic [CS_W-1:0]   cs_req,
  input  logic [FLEN_W-1:0] flen_req,
  output logic              cs_act,
  output logic [CS_W-1:0]   cs_idx
);
  logic              act_q, act_d;
  logic [CS_W-1:0]   idx_q, idx_d;
  logic [FLEN_W-1:0] flen_q, flen_d, wcnt_q, wcnt_d;

  assign cs_act = act_q;
  assign cs_idx = idx_q;

  always_comb begin
    act_d  = act_q;
    idx_d  = idx_q;
    flen_d = flen_q;
    wcnt_d = wcnt_q;
    if (inval) begin
      act_d  = 1'b0;
      wcnt_d = '0;
    end else if (start && !act_q) begin
      act_d  = 1'b1;
      idx_d  = cs_req;
      flen_d = flen_req;
      wcnt_d = '0;
    end else if (done) begin
      if (wcnt_q == flen_q) begin
        act_d  = 1'b0;
        wcnt_d = '0;
      end else begin
        wcnt_d = wcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      flen_q <= '0;
      wcnt_q <= '0;
    end else begin
      act_q  <= act_d;
      idx_q  <= idx_d;
      flen_q <= flen_d;
      wcnt_q <= wcnt_d;
    end
  end

  // R8: an invalidate leaves the select released
  a_r8_inval_release: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> !act_q);
  // R7: a word short of the frame end keeps the select
  a_r7_hold_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !inval && act_q && (wcnt_q != flen_q)) |=> act_q);
endmodule

// File: rtl/qspi_cmd_engine.sv
module qspi_cmd_engine
  import qspi_ce_pkg::*;
#(
  parameter int NCS    = 4,
  parameter int FLEN_W = 12,
  parameter int DIV_W  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [3:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           sclk_o,
  output logic [NCS-1:0] cs_o,
  output logic [3:0]     dq_o,
  output logic [3:0]     dq_oe,
  input  logic [3:0]     dq_i,
  output logic           irq_o
);
  localparam int CS_W  = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int DEV_W = 8 * NCS;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rstn_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rstn_i = rs_q[1];

  logic             clken_q, clken_d, err_q, err_d, ie_q, ie_d;
  logic             wcraw_q, wcraw_d, wcen_q, wcen_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DEV_W-1:0] dev_q, dev_d;
  logic [31:0]      cmd_q, cmd_d, txd_q, txd_d, rxw;
  logic             busy, done, lead, trail, slot_end, phase, tx_bit, tx_oe;
  logic             cs_act, cmd_wr, is_xfer, is_inv, start, inval;
  logic [CS_W-1:0]  cs_idx;
  logic [2:0]       fn_w;
  logic [7:0]       lane;
  logic [NCS-1:0]   cs_on;

  assign fn_w    = bus_wdata[CMD_FN_LSB +: 3];
  assign cmd_wr  = bus_we & (bus_addr == A_CMD);
  assign is_xfer = (fn_w == FN_WR1) | (fn_w == FN_RD1) | (fn_w == FN_RD2) | (fn_w == FN_RD4);
  assign is_inv  = (fn_w == FN_INV);
  assign start   = cmd_wr & ~busy & is_xfer;
  assign inval   = cmd_wr & ~busy & is_inv;
  assign lane    = dev_q[{cs_idx, 3'b000} +: 8];

  qspi_ce_bittimer #(.DIV_W(DIV_W)) u_tmr (
    .clk(clk), .rst_n(rstn_i), .run(busy), .clk_en(clken_q), .div(div_q),
    .lead(lead), .trail(trail), .slot_end(slot_end), .phase(phase));

  qspi_ce_shifter u_shf (
    .clk(clk), .rst_n(rstn_i), .start(start), .fn(fn_w),
    .wl(bus_wdata[CMD_WL_LSB +: 5]), .txw(txd_q), .cpha(lane[2]),
    .lead(lead), .trail(trail), .slot_end(slot_end), .dq_i(dq_i),
    .busy(busy), .done(done), .rxw(rxw), .tx_bit(tx_bit), .tx_oe(tx_oe));

  qspi_ce_frame #(.NCS(NCS), .FLEN_W(FLEN_W)) u_frm (
    .clk(clk), .rst_n(rstn_i), .start(start), .inval(inval), .done(done),
    .cs_req(bus_wdata[CMD_CS_LSB +: CS_W]), .flen_req(bus_wdata[FLEN_W-1:0]),
    .cs_act(cs_act), .cs_idx(cs_idx));

  always_comb begin
    clken_d = clken_q;
    div_d   = div_q;
    dev_d   = dev_q;
    cmd_d   = cmd_q;
    txd_d   = txd_q;
    ie_d    = ie_q;
    err_d   = err_q;
    wcraw_d = wcraw_q;
    wcen_d  = wcen_q;
    if (bus_we) begin
      case (bus_addr)
        A_CLK:   begin clken_d = bus_wdata[31]; div_d = bus_wdata[DIV_W-1:0]; end
        A_DEV:   dev_d = bus_wdata[DEV_W-1:0];
        A_DATA:  txd_d = bus_wdata;
        A_STAT:  if (bus_wdata[2]) err_d = 1'b0;
        A_IENS:  if (bus_wdata[1]) wcraw_d = 1'b0;
        A_IESET: if (bus_wdata[1]) wcen_d = 1'b1;
        A_IECLR: if (bus_wdata[1]) wcen_d = 1'b0;
        default: ;
      endcase
    end
    if (cmd_wr && busy) err_d = 1'b1;
    if (start || inval) begin
      cmd_d = bus_wdata;
      ie_d  = bus_wdata[CMD_IE_BIT] & start;
    end
    if (done && ie_q) wcraw_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rstn_i) begin
    if (!rstn_i) begin
      clken_q <= 1'b0;
      div_q   <= '0;
      dev_q   <= '0;
      cmd_q   <= '0;
      txd_q   <= '0;
      ie_q    <= 1'b0;
      err_q   <= 1'b0;
      wcraw_q <= 1'b0;
      wcen_q  <= 1'b0;
    end else begin
      clken_q <= clken_d;
      div_q   <= div_d;
      dev_q   <= dev_d;
      cmd_q   <= cmd_d;
      txd_q   <= txd_d;
      ie_q    <= ie_d;
      err_q   <= err_d;
      wcraw_q <= wcraw_d;
      wcen_q  <= wcen_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CLK:   bus_rdata = {clken_q, {(31-DIV_W){1'b0}}, div_q};
      A_DEV:   bus_rdata = 32'(dev_q);
      A_CMD:   bus_rdata = cmd_q;
      A_STAT:  bus_rdata = {29'd0, err_q, 1'b0, busy};
      A_DATA:  bus_rdata = rxw;
      A_IRAW:  bus_rdata = {30'd0, wcraw_q, 1'b0};
      A_IENS:  bus_rdata = {30'd0, wcraw_q & wcen_q, 1'b0};
      A_IESET,
      A_IECLR: bus_rdata = {30'd0, wcen_q, 1'b0};
      default: bus_rdata = '0;
    endcase
  end

  for (genvar n = 0; n < NCS; n++) begin : g_cs
    assign cs_o[n]  = (cs_act && (cs_idx == CS_W'(n))) ? dev_q[n*8+1] : ~dev_q[n*8+1];
    assign cs_on[n] = (cs_o[n] == dev_q[n*8+1]);
  end

  assign sclk_o = lane[0] ^ phase;
  assign dq_o   = {3'b000, tx_bit};
  assign dq_oe  = {3'b000, tx_oe};
  assign irq_o  = wcraw_q & wcen_q;

  // R7: never more than one select active at a time
  a_r7_one_select: assert property (@(posedge clk) disable iff (!rstn_i)
    $onehot0(cs_on));
  // R9: a command during a word raises the sticky error
  a_r9_err_on_busy: assert property (@(posedge clk) disable iff (!rstn_i)
    (cmd_wr && busy) |=> err_q);
  // R9: a command during a word leaves the readback untouched
  a_r9_cmd_kept: assert property (@(posedge clk) disable iff (!rstn_i)
    (cmd_wr && busy) |=> $stable(cmd_q));
  // R10: an armed word completion sets the raw flag
  a_r10_raw_on_done: assert property (@(posedge clk) disable iff (!rstn_i)
    (done && ie_q) |=> wcraw_q);
  // R8: an invalidate starts no word
  a_r8_no_shift: assert property (@(posedge clk) disable iff (!rstn_i)
    inval |=> !busy);
endmodule

// File: tb/sim_qspi_cmd_engine.sv
module sim_qspi_cmd_engine;
  import qspi_ce_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sclk_o, irq_o;
  logic [3:0]  cs_o, dq_o, dq_oe, dq_in;

  always #2 clk = ~clk;  // 250 MHz

  qspi_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk_o),
    .cs_o(cs_o), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_in), .irq_o(irq_o));

  int nchk = 0, nerr = 0, cycles = 0;
  logic [3:0] cpol, cspol, cpha;

  // serial slave model
  logic        sl_on = 1'b0, prev_sclk = 1'b0;
  logic [31:0] sl_word = '0, mosi_cap = '0;
  int          sl_nb = 8, sl_ln = 1, sl_idx = 0, cur_cs = 0;

  always_comb begin
    int pos;
    dq_in = '0;
    for (int k = 0; k < 4; k++) begin
      pos = sl_nb - 1 - sl_idx * sl_ln - k;
      if (sl_on && k < sl_ln && pos >= 0 && pos < 32) begin
        if (sl_ln == 1) dq_in[1] = sl_word[pos];
        else            dq_in[sl_ln-1-k] = sl_word[pos];
      end
    end
  end

  always @(negedge clk) begin
    if (sl_on && sclk_o != prev_sclk) begin
      if ((sclk_o != cpol[cur_cs]) != cpha[cur_cs]) begin
        mosi_cap = {mosi_cap[30:0], dq_o[0]};
        sl_idx   = sl_idx + 1;
      end
    end
    prev_sclk = sclk_o;
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      nerr = nerr + 1;
      nchk = nchk + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (!ok) begin
      nerr = nerr + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] mask_of(input int nb);
    return (nb == 32) ? 32'hffff_ffff : ((32'd1 << nb) - 32'd1);
  endfunction

  function automatic int lines_of(input logic [2:0] fn);
    return (fn == FN_RD4) ? 4 : (fn == FN_RD2) ? 2 : 1;
  endfunction

  function automatic int exp_busy(input int nb, input int ln, input int dv);
    return (nb / ln) * (((dv == 0) ? 1 : dv) + 1);
  endfunction

  function automatic logic [31:0] mk_cmd(input int cs, input int nb, input logic [2:0] fn,
                                         input bit ie, input int fl);
    return (32'(cs) << 28) | (32'(nb - 1) << 19) | (32'(fn) << 16) | (32'(ie) << 14) | 32'(fl);
  endfunction

  function automatic logic [31:0] dev_word();
    logic [31:0] w = '0;
    for (int n = 0; n < 4; n++) w[n*8 +: 3] = {cpha[n], cspol[n], cpol[n]};
    return w;
  endfunction

  task automatic launch(input int cs, input int nb, input logic [2:0] fn,
                        input logic [31:0] sw, input logic [31:0] cmd);
    sl_word = sw; sl_nb = nb; sl_ln = lines_of(fn); sl_idx = 0; mosi_cap = '0; cur_cs = cs;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = A_CMD; bus_wdata = cmd;
    @(posedge clk);
    #1 bus_we = 1'b0;
    prev_sclk = sclk_o;
    sl_on = 1'b1;
  endtask

  task automatic wait_done(input bit exp_oe, output int cyc);
    logic [31:0] s;
    cyc = 0;
    forever begin
      @(negedge clk);
      rd(A_STAT, s);
      if (!s[0] || cyc > 100000) break;
      cyc = cyc + 1;
      if (cyc == 1) begin
        chk(cs_o[cur_cs] == cspol[cur_cs], "R6 select active level", 32'(cs_o), 32'(cspol[cur_cs]));
        chk(dq_oe[0] == exp_oe, "R1 output enable", 32'(dq_oe), 32'(exp_oe));
      end
    end
    sl_on = 1'b0;
  endtask

  // one complete single-word transfer with full checking
  task automatic xfer(input int cs, input int nb, input logic [2:0] fn, input int dv,
                      input logic [31:0] txw, input logic [31:0] sw, input bit ie, input int fl);
    int cyc;
    logic [31:0] r;
    if (fn == FN_WR1) wr(A_DATA, txw);
    launch(cs, nb, fn, sw, mk_cmd(cs, nb, fn, ie, fl));
    wait_done(fn == FN_WR1, cyc);
    chk(cyc == exp_busy(nb, lines_of(fn), dv), "R4 busy length", 32'(cyc),
        32'(exp_busy(nb, lines_of(fn), dv)));
    if (fn == FN_WR1) begin
      chk((mosi_cap & mask_of(nb)) == (txw & mask_of(nb)), "R1 write data MSB first",
          mosi_cap & mask_of(nb), txw & mask_of(nb));
    end else begin
      rd(A_DATA, r);
      chk(r == (sw & mask_of(nb)), "R2 read data lines", r, sw & mask_of(nb));
    end
  endtask

  initial begin
    logic [31:0] r, c1;
    int cyc;
    void'($urandom(32'h5eed_0123));
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    cpol = '0; cspol = '0; cpha = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R11: reset state
    @(negedge clk);
    rd(A_CLK, r);  chk(r == 0, "R11 clock control reset", r, 0);
    rd(A_STAT, r); chk(r == 0, "R11 status reset", r, 0);
    chk(cs_o == 4'hf, "R11 selects inactive", 32'(cs_o), 32'hf);
    chk(sclk_o == 1'b0 && irq_o == 1'b0, "R11 sclk and irq low", {sclk_o, irq_o}, 0);

    // randomized single-word frames
    for (int it = 0; it < 48; it++) begin
      int cs, nb, dv;
      logic [2:0] fn;
      bit ie;
      logic [31:0] txw, sw;
      cpol = 4'($urandom); cspol = 4'($urandom); cpha = 4'($urandom);
      wr(A_DEV, dev_word());
      cs = int'($urandom % 4);
      dv = int'($urandom % 6);
      wr(A_CLK, 32'h8000_0000 | 32'(dv));
      case ($urandom % 3) 0: nb = 8; 1: nb = 16; default: nb = 32; endcase
      case ($urandom % 4) 0: fn = FN_WR1; 1: fn = FN_RD1; 2: fn = FN_RD2; default: fn = FN_RD4; endcase
      ie = 1'($urandom);
      txw = $urandom; sw = $urandom;
      xfer(cs, nb, fn, dv, txw, sw, ie, 0);
      @(negedge clk);
      chk(cs_o == ~cspol, "R7 single-word frame released", 32'(cs_o), 32'(~cspol));
      chk(sclk_o == cpol[cs], "R6 idle clock level", 32'(sclk_o), 32'(cpol[cs]));
      rd(A_IRAW, r);
      chk(r[1] == ie, "R10 raw flag follows arm bit", r, 32'(ie) << 1);
      chk(irq_o == 1'b0, "R10 irq masked while disabled", 32'(irq_o), 0);
      wr(A_IENS, 32'h2);
    end

    // directed: three-word frame on select 2 (R7)
    cpol = 4'b0100; cspol = 4'b0000; cpha = 4'b0100;
    wr(A_DEV, dev_word());
    wr(A_CLK, 32'h8000_0001);
    for (int w = 0; w < 3; w++) begin
      logic [31:0] d;
      d = 32'hA5C3_0000 + 32'(w);
      xfer(2, 16, FN_WR1, 1, d, 0, 1'b0, 2);
      @(negedge clk);
      if (w < 2) chk(cs_o[2] == 1'b0, "R7 select held inside frame", 32'(cs_o), 32'hb);
      else       chk(cs_o == 4'hf, "R7 select released at frame end", 32'(cs_o), 32'hf);
    end

    // directed: invalidate mid frame (R8)
    cspol = 4'b0010;
    wr(A_DEV, dev_word());
    xfer(1, 8, FN_RD4, 1, 0, 32'h0000_005a, 1'b0, 5);
    @(negedge clk);
    chk(cs_o[1] == 1'b1, "R8 select active before invalidate", 32'(cs_o), 32'h2);
    wr(A_CMD, mk_cmd(1, 8, FN_INV, 1'b1, 0));
    @(negedge clk);
    chk(cs_o[1] == 1'b0, "R8 invalidate releases select", 32'(cs_o), 32'h0);
    rd(A_STAT, r); chk(r[0] == 1'b0, "R8 invalidate shifts nothing", r, 0);
    rd(A_IRAW, r); chk(r[1] == 1'b0, "R8 invalidate raises no interrupt", r, 0);
    rd(A_CMD, r);  chk(r[18:16] == FN_INV, "R1 invalidate code accepted", r, 32'(FN_INV) << 16);

    // directed: unknown function code does nothing (R1)
    wr(A_CMD, mk_cmd(0, 8, 3'd5, 1'b0, 0));
    @(negedge clk);
    rd(A_STAT, r); chk(r[0] == 1'b0, "R1 unknown code starts no word", r, 0);
    chk(cs_o == 4'b1101, "R1 unknown code moves no select", 32'(cs_o), 32'hd);

    // directed: command while busy (R9)
    wr(A_CLK, 32'h8000_0005);
    c1 = mk_cmd(0, 32, FN_RD1, 1'b0, 0);
    cur_cs = 0;
    wr(A_CMD, c1);
    wr(A_CMD, mk_cmd(3, 8, FN_WR1, 1'b0, 0));
    @(negedge clk);
    rd(A_STAT, r); chk(r[2:0] == 3'b101, "R9 busy and sticky error", r, 5);
    chk(cs_o[3] == ~cspol[3], "R9 ignored command moves no select", 32'(cs_o), 32'(~cspol[3]));
    wait_done(1'b0, cyc);
    chk(cyc > 150 && cyc < 192, "R9 first word runs undisturbed", 32'(cyc), 190);
    rd(A_CMD, r); chk(r == c1, "R9 readback unchanged", r, c1);
    rd(A_STAT, r); chk(r[2] == 1'b1, "R9 error stays set", r, 4);
    wr(A_STAT, 32'h4);
    @(negedge clk);
    rd(A_STAT, r); chk(r[2] == 1'b0, "R9 error cleared by write one", r, 0);

    // directed: clock gate (R5)
    cpol = 4'b0001; cpha = 4'b0000; cspol = 4'b0000;
    wr(A_DEV, dev_word());
    wr(A_CLK, 32'h0000_0002);
    wr(A_DATA, 32'h0000_00c6);
    launch(0, 8, FN_WR1, 0, mk_cmd(0, 8, FN_WR1, 1'b1, 0));
    begin
      bit moved = 1'b0;
      repeat (40) begin
        @(negedge clk);
        if (sclk_o != 1'b1) moved = 1'b1;
      end
      chk(!moved, "R5 sclk still while gated", 32'(moved), 0);
    end
    rd(A_STAT, r); chk(r[0] == 1'b1, "R5 busy held while gated", r, 1);
    wr(A_IESET, 32'h2);
    wr(A_CLK, 32'h8000_0002);
    wait_done(1'b1, cyc);
    chk(mosi_cap[7:0] == 8'hc6, "R5 word completes after enable", mosi_cap, 32'hc6);

    // directed: interrupt path (R10)
    @(negedge clk);
    chk(irq_o == 1'b1, "R10 irq asserted when enabled", 32'(irq_o), 1);
    rd(A_IENS, r); chk(r == 32'h2, "R10 masked view set", r, 2);
    wr(A_IECLR, 32'h2);
    @(negedge clk);
    chk(irq_o == 1'b0, "R10 enable clear masks irq", 32'(irq_o), 0);
    rd(A_IRAW, r); chk(r == 32'h2, "R10 raw kept after enable clear", r, 2);
    wr(A_IESET, 32'h2);
    wr(A_IENS, 32'h2);
    @(negedge clk);
    rd(A_IRAW, r); chk(r == 0, "R10 write one clears raw", r, 0);
    chk(irq_o == 1'b0, "R10 irq low after clear", 32'(irq_o), 0);

    // directed: divider zero acts as one, quad 32-bit word (R3, R4)
    wr(A_CLK, 32'h8000_0000);
    xfer(0, 32, FN_RD4, 0, 0, 32'h1234_5678, 1'b0, 0);
    xfer(0, 8, FN_RD2, 0, 0, 32'hffff_ff96, 1'b0, 0);

    summary();
    $finish;
  end
endmodule